// File: doc/BRIEF.md
# Per-Process Paged Address Translator

This block turns a 16-bit virtual address issued by the running process into a real address. The upper five address bits pick one of 32 page-map entries kept separately for each of up to 64 processes. The entry gives a real page number, and the 11-bit offset inside a 2 KiB page passes through unchanged. A second table, indexed by real page number, holds a present bit, a device bit, a writable bit and a per-process write-permission mask. A lookup that fails raises a fault with a cause code, and a lookup that succeeds raises a valid strobe. Both appear one clock after the request.

Virtual page 31 is special. In every process it resolves through process 0's entry for page 31, so all processes share one page. Any process may read it, but writes to it succeed only with the shared-stack qualifier. The supervisor flag tracks the process number: it is set while process 0 runs and clear otherwise. Only the supervisor may write the tables or the translation-enable control. Only the supervisor may issue long 32-bit addresses that skip translation. Translation comes out of reset switched off. While it is off, every access reaches the low 64 KiB directly.

Top module: `page_xlate`

## Requirements
- R1: After reset, valid_o and fault_o are low, sup_o is high, and translation is disabled.
- R2: With translation disabled, a request yields valid_o with raddr_o equal to the low 16 address bits zero-extended and dev_o low. No table is consulted and no fault is raised.
- R3: With translation enabled, virtual page addr_i[15:11] of process proc_i selects map entry {proc_i, page}. raddr_o is {real page number, addr_i[10:0]} zero-extended, and dev_o is the real page's device bit.
- R4: valid_o or fault_o rises only in the cycle after a cycle with req_i high. The two are never high together, and a cycle without a request produces neither.
- R5: An access whose map entry has its exists bit clear faults with cause 1.
- R6: An access whose real page number is not below the real-page count, or whose real page has its present bit clear, faults with cause 2.
- R7: A write to an ordinary page succeeds only when the real page is writable and the mask bit indexed by proc_i is set. Otherwise it faults with cause 3. Reads ignore both the writable bit and the mask.
- R8: Virtual page 31 always uses process 0's page-31 entry. Reads of it are permitted. Writes to it succeed only with stack_i high, regardless of writable bit and mask, and fault with cause 3 otherwise.
- R9: sup_o is high in the cycle after a clock edge at which proc_i was 0, and low after an edge at which proc_i was nonzero.
- R10: Table writes (tw_en_i) take effect only while sup_o is high and are ignored otherwise. tw_sel_i selects the target. Select 0 writes a map entry at tw_addr_i = {process, page}, with data bits 19:0 as the real page number and bit 20 as exists. Select 1 writes attributes at tw_addr_i[5:0], with data bit 0 present, bit 1 device and bit 2 writable. Select 2 writes that page's 64-bit write mask. Select 3 writes the translation enable from data bit 0.
- R11: With translation enabled and sup_o high, a request with long_i high passes all 32 address bits to raddr_o unchecked. With sup_o low, long_i is ignored and the access is translated.
- R12: When fault_en_i is low, a faulting access produces neither fault_o nor valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_i | input | 6 | Current process number |
| req_i | input | 1 | Access request |
| we_i | input | 1 | Request is a write |
| long_i | input | 1 | Supervisor long address, skips translation |
| stack_i | input | 1 | Access is a shared-stack push or pop |
| fault_en_i | input | 1 | Faults may be reported |
| addr_i | input | 32 | Address; low 16 bits are the virtual address |
| tw_en_i | input | 1 | Table write strobe |
| tw_sel_i | input | 2 | Table write target select |
| tw_addr_i | input | 11 | Table write index |
| tw_data_i | input | 64 | Table write data |
| valid_o | output | 1 | Access translated and permitted |
| raddr_o | output | 32 | Real address |
| dev_o | output | 1 | Real page is a device |
| fault_o | output | 1 | Access faulted |
| cause_o | output | 2 | Fault cause: 1 not exists, 2 not present, 3 write denied |
| sup_o | output | 1 | Supervisor flag |

## Verification
The bench keeps the defaults: 64 processes, 32 virtual pages, 31-bit real addresses and 64 real pages. At these sizes it can fill every one of the 2048 map entries and every real-page mask with random contents. Because real page numbers are drawn up to 79, the out-of-range fault path is reached alongside the present-bit path. With 64 processes, the mask bits of processes far from 0 are checked, including the top bit of the mask word.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    CZ_NONE    = 2'd0,
    CZ_NOEXIST = 2'd1,
    CZ_ABSENT  = 2'd2,
    CZ_DENIED  = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    TS_PMAP  = 2'd0,
    TS_ATTR  = 2'd1,
    TS_WMASK = 2'd2,
    TS_CTL   = 2'd3
  } tsel_e;

endpackage

// File: rtl/xlate_pmap.sv
// Per-process page map: one entry per (process, virtual page).
module xlate_pmap #(
  parameter int NPROC  = 64,
  parameter int VPAGES = 32,
  parameter int RPN_W  = 20
) (
  input  logic                                  clk,
  input  logic                                  we,
  input  logic [$clog2(NPROC*VPAGES)-1:0]       waddr,
  input  logic [RPN_W:0]                        wdata,
  input  logic [$clog2(NPROC*VPAGES)-1:0]       raddr,
  output logic                                  exists,
  output logic [RPN_W-1:0]                      rpn
);
  localparam int DEPTH = NPROC * VPAGES;

  logic [RPN_W:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign exists = mem[raddr][RPN_W];
  assign rpn    = mem[raddr][RPN_W-1:0];
endmodule

// File: rtl/xlate_ptab.sv
// Real page table: attributes and per-process write mask.
module xlate_ptab #(
  parameter int NREAL = 64,
  parameter int NPROC = 64
) (
  input  logic                     clk,
  input  logic                     attr_we,
  input  logic                     mask_we,
  input  logic [$clog2(NREAL)-1:0] waddr,
  input  logic [NPROC-1:0]         wdata,
  input  logic [$clog2(NREAL)-1:0] ridx,
  output logic                     present,
  output logic                     device,
  output logic                     writable,
  output logic [NPROC-1:0]         wmask
);
  localparam int ATTR_W = 3;

  logic [ATTR_W-1:0] attr_mem [NREAL];
  logic [NPROC-1:0]  mask_mem [NREAL];

  always_ff @(posedge clk) begin
    if (attr_we) attr_mem[waddr] <= wdata[ATTR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (mask_we) mask_mem[waddr] <= wdata;
  end

  assign present  = attr_mem[ridx][0];
  assign device   = attr_mem[ridx][1];
  assign writable = attr_mem[ridx][2];
  assign wmask    = mask_mem[ridx];
endmodule

// File: rtl/xlate_mode.sv
// Supervisor flag (follows process 0) and translation enable.
module xlate_mode (
  input  logic clk,
  input  logic rst,
  input  logic proc_zero,
  input  logic ctl_we,
  input  logic ctl_d,
  output logic sup,
  output logic mmu_on
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sup    <= 1'b1;
      mmu_on <= 1'b0;
    end else begin
      sup <= proc_zero;
      if (ctl_we) mmu_on <= ctl_d;
    end
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int NPROC  = 64,
  parameter int VA_W   = 16,
  parameter int OFF_W  = 11,
  parameter int RA_W   = 31,
  parameter int PA_W   = 32,
  parameter int NREAL  = 64
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [$clog2(NPROC)-1:0]          proc_i,
  input  logic                              req_i,
  input  logic                              we_i,
  input  logic                              long_i,
  input  logic                              stack_i,
  input  logic                              fault_en_i,
  input  logic [PA_W-1:0]                   addr_i,
  input  logic                              tw_en_i,
  input  logic [1:0]                        tw_sel_i,
  input  logic [$clog2(NPROC)+VA_W-OFF_W-1:0] tw_addr_i,
  input  logic [((NPROC > RA_W-OFF_W+1) ? NPROC : RA_W-OFF_W+1)-1:0] tw_data_i,
  output logic                              valid_o,
  output logic [PA_W-1:0]                   raddr_o,
  output logic                              dev_o,
  output logic                              fault_o,
  output logic [1:0]                        cause_o,
  output logic                              sup_o
);
  import xlate_pkg::*;

  localparam int PROC_W = $clog2(NPROC);
  localparam int VPG_W  = VA_W - OFF_W;
  localparam int VPAGES = 2 ** VPG_W;
  localparam int RPN_W  = RA_W - OFF_W;
  localparam int NR_W   = $clog2(NREAL);
  localparam int MIDX_W = PROC_W + VPG_W;

  // Mode state
  logic mmu_on;
  logic ctl_we;

  assign ctl_we = tw_en_i && sup_o && (tw_sel_i == TS_CTL);

  xlate_mode u_mode (
    .clk       (clk),
    .rst       (rst),
    .proc_zero (proc_i == '0),
    .ctl_we    (ctl_we),
    .ctl_d     (tw_data_i[0]),
    .sup       (sup_o),
    .mmu_on    (mmu_on)
  );

  // Page map lookup
  logic [VPG_W-1:0]  vpg;
  logic              shared_pg;
  logic [PROC_W-1:0] map_proc;
  logic [MIDX_W-1:0] map_idx;
  logic              pe_exists;
  logic [RPN_W-1:0]  pe_rpn;

  assign vpg       = addr_i[VA_W-1:OFF_W];
  assign shared_pg = (vpg == VPG_W'(VPAGES - 1));
  assign map_proc  = shared_pg ? '0 : proc_i;
  assign map_idx   = {map_proc, vpg};

  xlate_pmap #(
    .NPROC  (NPROC),
    .VPAGES (VPAGES),
    .RPN_W  (RPN_W)
  ) u_pmap (
    .clk    (clk),
    .we     (tw_en_i && sup_o && (tw_sel_i == TS_PMAP)),
    .waddr  (tw_addr_i),
    .wdata  (tw_data_i[RPN_W:0]),
    .raddr  (map_idx),
    .exists (pe_exists),
    .rpn    (pe_rpn)
  );

  // Real page lookup
  logic             rp_present;
  logic             rp_device;
  logic             rp_writable;
  logic [NPROC-1:0] rp_wmask;
  logic             in_range;

  assign in_range = (pe_rpn < RPN_W'(NREAL));

  xlate_ptab #(
    .NREAL (NREAL),
    .NPROC (NPROC)
  ) u_ptab (
    .clk      (clk),
    .attr_we  (tw_en_i && sup_o && (tw_sel_i == TS_ATTR)),
    .mask_we  (tw_en_i && sup_o && (tw_sel_i == TS_WMASK)),
    .waddr    (tw_addr_i[NR_W-1:0]),
    .wdata    (tw_data_i[NPROC-1:0]),
    .ridx     (pe_rpn[NR_W-1:0]),
    .present  (rp_present),
    .device   (rp_device),
    .writable (rp_writable),
    .wmask    (rp_wmask)
  );

  // Checks
  logic   wr_ok;
  cause_e cause_c;

  assign wr_ok = shared_pg ? stack_i : (rp_writable && rp_wmask[proc_i]);

  always_comb begin
    cause_c = CZ_NONE;
    if (!pe_exists)                    cause_c = CZ_NOEXIST;
    else if (!in_range || !rp_present) cause_c = CZ_ABSENT;
    else if (we_i && !wr_ok)           cause_c = CZ_DENIED;
  end

  // Registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      fault_o <= 1'b0;
      cause_o <= CZ_NONE;
      raddr_o <= '0;
      dev_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      fault_o <= 1'b0;
      cause_o <= CZ_NONE;
      if (req_i) begin
        if (!mmu_on) begin
          valid_o <= 1'b1;
          raddr_o <= PA_W'(addr_i[VA_W-1:0]);
          dev_o   <= 1'b0;
        end else if (sup_o && long_i) begin
          valid_o <= 1'b1;
          raddr_o <= addr_i;
          dev_o   <= 1'b0;
        end else if (cause_c == CZ_NONE) begin
          valid_o <= 1'b1;
          raddr_o <= PA_W'({pe_rpn, addr_i[OFF_W-1:0]});
          dev_o   <= rp_device;
        end else if (fault_en_i) begin
          fault_o <= 1'b1;
          cause_o <= cause_c;
        end
      end
    end
  end
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
  parameter int PROC_W = 6,
  parameter int PA_W   = 32,
  parameter int OFF_W  = 11
) (
  input logic              clk,
  input logic              rst,
  input logic [PROC_W-1:0] proc_i,
  input logic              req_i,
  input logic              long_i,
  input logic              fault_en_i,
  input logic [PA_W-1:0]   addr_i,
  input logic              valid_o,
  input logic [PA_W-1:0]   raddr_o,
  input logic              fault_o,
  input logic [1:0]        cause_o,
  input logic              sup_o
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst) !(valid_o && fault_o)); // R4
  AST_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst) (valid_o || fault_o) |-> $past(req_i)); // R4
  AST_FAULT_GATED: assert property (@(posedge clk) disable iff (rst) fault_o |-> $past(fault_en_i)); // R12
  AST_CAUSE_SET: assert property (@(posedge clk) disable iff (rst) fault_o |-> (cause_o != 2'd0)); // R5
  AST_SUP_TRACK: assert property (@(posedge clk) disable iff (rst) !rst |=> (sup_o == ($past(proc_i) == '0))); // R9
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !$past(long_i)) |-> (raddr_o[OFF_W-1:0] == $past(addr_i[OFF_W-1:0]))); // R3
endmodule

bind page_xlate page_xlate_chk #(
  .PROC_W ($clog2(NPROC)),
  .PA_W   (PA_W),
  .OFF_W  (OFF_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .proc_i     (proc_i),
  .req_i      (req_i),
  .long_i     (long_i),
  .fault_en_i (fault_en_i),
  .addr_i     (addr_i),
  .valid_o    (valid_o),
  .raddr_o    (raddr_o),
  .fault_o    (fault_o),
  .cause_o    (cause_o),
  .sup_o      (sup_o)
);

// File: tb/page_xlate_bench.sv
module page_xlate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPROC = 64;
  localparam int NREAL = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  proc_i = '0;
  logic        req_i = 0, we_i = 0, long_i = 0, stack_i = 0, fault_en_i = 1;
  logic [31:0] addr_i = '0;
  logic        tw_en_i = 0;
  logic [1:0]  tw_sel_i = '0;
  logic [10:0] tw_addr_i = '0;
  logic [63:0] tw_data_i = '0;
  logic        valid_o, dev_o, fault_o, sup_o;
  logic [31:0] raddr_o;
  logic [1:0]  cause_o;

  page_xlate u_page_xlate (
    .clk(clk), .rst(rst), .proc_i(proc_i), .req_i(req_i), .we_i(we_i),
    .long_i(long_i), .stack_i(stack_i), .fault_en_i(fault_en_i), .addr_i(addr_i),
    .tw_en_i(tw_en_i), .tw_sel_i(tw_sel_i), .tw_addr_i(tw_addr_i), .tw_data_i(tw_data_i),
    .valid_o(valid_o), .raddr_o(raddr_o), .dev_o(dev_o), .fault_o(fault_o),
    .cause_o(cause_o), .sup_o(sup_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // Bench model of the tables
  logic [20:0] pmap_m [2048];
  logic [2:0]  attr_m [NREAL];
  logic [63:0] mask_m [NREAL];
  logic        mmu_m = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {valid, fault, cause[1:0], raddr[31:0], dev}
  function automatic logic [36:0] model(input logic [5:0] p, input logic [31:0] a,
      input bit we, input bit stk, input bit fen, input bit lng);
    logic v, f, d; logic [1:0] c; logic [31:0] r;
    logic [4:0] vp; logic shr; logic [5:0] ep; logic [20:0] e; logic [19:0] rpn; bit ok;
    v = 0; f = 0; d = 0; c = 0; r = 0;
    if (!mmu_m) begin
      v = 1; r = {16'h0, a[15:0]};
    end else if (p == 0 && lng) begin
      v = 1; r = a;
    end else begin
      vp = a[15:11]; shr = (vp == 5'd31); ep = shr ? 6'd0 : p;
      e = pmap_m[{ep, vp}]; rpn = e[19:0];
      if (!e[20]) c = 1;
      else if (rpn >= 20'(NREAL) || !attr_m[rpn[5:0]][0]) c = 2;
      else if (we) begin
        ok = shr ? stk : (attr_m[rpn[5:0]][2] && mask_m[rpn[5:0]][p]);
        if (!ok) c = 3;
      end
      if (c != 0) f = fen;
      else begin v = 1; r = {1'b0, rpn, a[10:0]}; d = attr_m[rpn[5:0]][1]; end
    end
    return {v, f, f ? c : 2'b0, v ? r : 32'h0, v ? d : 1'b0};
  endfunction

  task automatic tw(input logic [5:0] p, input logic [1:0] sel, input logic [10:0] ad, input logic [63:0] d);
    @(negedge clk); proc_i = p;
    @(negedge clk); tw_en_i = 1; tw_sel_i = sel; tw_addr_i = ad; tw_data_i = d;
    @(negedge clk); tw_en_i = 0;
    if (p == 0) begin  // R10: only supervisor writes land
      case (sel)
        2'd0: pmap_m[ad] = d[20:0];
        2'd1: attr_m[ad[5:0]] = d[2:0];
        2'd2: mask_m[ad[5:0]] = d;
        default: mmu_m = d[0];
      endcase
    end
  endtask

  task automatic xact(input logic [5:0] p, input logic [31:0] a, input bit we, input bit stk,
      input bit fen, input bit lng, input string tag);
    logic [36:0] exp, act;
    @(negedge clk); proc_i = p; req_i = 0;
    @(negedge clk); req_i = 1; addr_i = a; we_i = we; stack_i = stk; fault_en_i = fen; long_i = lng;
    exp = model(p, a, we, stk, fen, lng);
    @(negedge clk); req_i = 0;
    act = {valid_o, fault_o, fault_o ? cause_o : 2'b0, valid_o ? raddr_o : 32'h0, valid_o ? dev_o : 1'b0};
    check(act == exp, tag, 64'(act), 64'(exp));
  endtask

  function automatic logic [31:0] va(input int pg, input int off);
    return {16'h0, 5'(pg), 11'(off)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!valid_o && !fault_o && sup_o, "R1 reset state", {61'b0, valid_o, fault_o, sup_o}, 64'h1);

    // R2 / R1: translation off after reset
    xact(6'd3, 32'hABCD_1234, 1, 0, 1, 0, "R2 passthrough write");
    xact(6'd3, 32'h0000_F800, 0, 0, 1, 1, "R2 passthrough long ignored");
    check(!sup_o, "R9 sup low after proc 3", {63'b0, sup_o}, 64'h0);
    // R10: non-supervisor enable attempt is ignored
    tw(6'd3, 2'd3, 11'd0, 64'h1);
    xact(6'd3, 32'h0000_9ABC, 0, 0, 1, 0, "R10 ctl write ignored");

    // Fill tables as supervisor
    for (int i = 0; i < 2048; i++)
      tw(6'd0, 2'd0, 11'(i), 64'({($urandom_range(3, 0) != 0), 20'($urandom_range(79, 0))}));
    for (int i = 0; i < NREAL; i++) begin
      tw(6'd0, 2'd1, 11'(i), 64'($urandom_range(7, 0)));
      tw(6'd0, 2'd2, 11'(i), {$urandom, $urandom});
    end
    check(sup_o, "R9 sup high after proc 0", {63'b0, sup_o}, 64'h1);
    // Directed entries
    tw(0, 2'd0, {6'd2, 5'd3},  64'h10_0005);
    tw(0, 2'd0, {6'd2, 5'd4},  64'h00_0005);
    tw(0, 2'd0, {6'd2, 5'd6},  64'h10_0046);
    tw(0, 2'd0, {6'd2, 5'd7},  64'h10_0009);
    tw(0, 2'd0, {6'd4, 5'd3},  64'h10_0005);
    tw(0, 2'd0, {6'd0, 5'd31}, 64'h10_000C);
    tw(0, 2'd0, {6'd2, 5'd31}, 64'h00_0000);
    tw(0, 2'd0, {6'd63, 5'd2}, 64'h10_0005);
    tw(0, 2'd1, 11'd5,  64'h7);
    tw(0, 2'd2, 11'd5,  64'h8000_0000_0000_0004);
    tw(0, 2'd1, 11'd9,  64'h6);
    tw(0, 2'd1, 11'd12, 64'h1);
    tw(0, 2'd2, 11'd12, 64'h0);
    tw(0, 2'd3, 11'd0,  64'h1);

    xact(2, va(3, 11'h155), 0, 0, 1, 0, "R3 translate read");
    xact(2, va(3, 11'h7FF), 1, 0, 1, 0, "R7 permitted write");
    xact(4, va(3, 11'h010), 1, 0, 1, 0, "R7 mask denies write");
    xact(4, va(3, 11'h010), 0, 0, 1, 0, "R7 read ignores mask");
    xact(63, va(2, 11'h3AA), 1, 0, 1, 0, "R7 top mask bit");
    xact(2, va(4, 11'h001), 0, 0, 1, 0, "R5 not exists");
    xact(2, va(6, 11'h002), 0, 0, 1, 0, "R6 page out of range");
    xact(2, va(7, 11'h003), 0, 0, 1, 0, "R6 present clear");
    xact(2, va(31, 11'h0F0), 0, 0, 1, 0, "R8 shared read");
    xact(2, va(31, 11'h0F0), 1, 0, 1, 0, "R8 shared write no stack");
    xact(2, va(31, 11'h0F4), 1, 1, 1, 0, "R8 shared stack write");
    xact(0, va(31, 11'h0F8), 1, 0, 1, 0, "R8 shared write proc0 no stack");
    xact(2, va(4, 11'h001), 0, 0, 0, 0, "R12 fault dropped");
    xact(0, 32'h8765_4321, 1, 0, 1, 1, "R11 long supervisor");
    xact(2, 32'h8765_1955, 0, 0, 1, 1, "R11 long ignored user");
    tw(2, 2'd0, {6'd2, 5'd3}, 64'h10_0006);
    xact(2, va(3, 11'h155), 0, 0, 1, 0, "R10 map write ignored");

    @(negedge clk); req_i = 0;
    @(negedge clk);
    check(!valid_o && !fault_o, "R4 idle no strobe", {62'b0, valid_o, fault_o}, 64'h0);

    // Random mix
    for (int k = 0; k < 1500; k++) begin
      int sel = $urandom_range(9, 0);
      if (sel == 0)
        tw(6'($urandom_range(3, 0)), 2'($urandom_range(2, 0)), 11'($urandom),
           {$urandom, 11'h0, 1'($urandom), 20'($urandom_range(79, 0))});
      else
        xact(6'($urandom_range(NPROC - 1, 0)) & (($urandom_range(4, 0) == 0) ? 6'd0 : 6'h3F),
             $urandom, 1'($urandom), 1'($urandom), ($urandom_range(5, 0) != 0),
             ($urandom_range(3, 0) == 0), "R3 R5 R6 R7 R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule